// File: doc/BRIEF.md
# Data Watchpoint Comparator Bank

This block watches the data side of a processor pipeline for loads and stores that touch addresses a debugger has marked. It holds a small bank of watch units. Each unit has an address register and a control word. The control word sets four things: whether the unit is armed, which access directions it reacts to, how many low address bits it ignores (so that an aligned block is watched rather than one byte), and whether it also needs a context condition from the breakpoint bank.

Every cycle the bank compares a presented data access against all armed units in parallel. A matching access moves a two-state reporting machine into its reporting state on the next clock edge. At that edge the bank also registers the index of the winning unit and the accessed address, so an exception handler can find the address that tripped the watch. Instruction fetches are never watched. Taking the exception is left to the surrounding core.

Reporting machine states and transitions:
- `ST_WATCH`: no hit is shown. A matching access takes **T_FIRE** to `ST_REPORT`. Any other cycle takes **T_IDLE** and stays in `ST_WATCH`.
- `ST_REPORT`: hit is shown for one cycle. A further matching access takes **T_REFIRE** and stays in `ST_REPORT` with the captures refreshed. Otherwise **T_CLEAR** returns to `ST_WATCH`.

Top module: `wp_bank`

## Requirements
- R1: Output `id_units` is constant and equals the number of implemented units minus one (`NUM_WP` from 2 to 16).
- R2: Control bit 0 arms a unit. A disarmed unit never causes a hit.
- R3: Control bits [7:3] give a count m of low address bits left out of the comparison, so the aligned 2^m-byte block containing the value address is watched. Addresses outside that block do not hit.
- R4: A mask count of 1 or 2 is reserved and behaves exactly as 0, meaning the full address is compared.
- R5: Control bits [2:1] select the direction: 2'b01 reads only, 2'b10 writes only, 2'b11 both, and 2'b00 never matches. `acc_write`=1 marks a write and 0 marks a read.
- R6: An access with `acc_ifetch`=1 never causes a hit.
- R7: When control bit 8 is set, the unit fires only if bit `ctx_match[k]` is 1, where k is control bits [12:9]. A k at or above `CTX_W` never fires.
- R8: When several units match in the same cycle, the lowest unit index is reported on `hit_idx`.
- R9: `fault_addr` loads the access address only on a hit and holds it, across non-matching accesses, until the next hit.
- R10: `hit` is high for exactly the cycle after each matching access (T_FIRE/T_REFIRE). It drops the cycle after a non-matching or absent access (T_CLEAR). Back-to-back matches keep it high with the captures refreshed.
- R11: A configuration write (`cfg_sel`=0 for the value address, 1 for the control word) to unit `cfg_idx` applies from the next cycle. Indices at or above `NUM_WP` are ignored. Reset clears all units to disarmed with zero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = value address, 1 = control word |
| cfg_idx | input | 4 | Target unit index |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| ctx_match | input | CTX_W | Context conditions from the breakpoint bank |
| hit | output | 1 | Watch hit reported |
| hit_idx | output | IDX_W | Index of the reporting unit |
| fault_addr | output | ADDR_W | Address captured at the last hit |
| id_units | output | 4 | Implemented unit count minus one |

## Verification
The assertions check, on every cycle, the properties that the ports alone can express:
- a fetch or an absent access never produces a hit in the next cycle;
- the captured address equals the previous cycle's access address whenever hit is high;
- the captured address holds steady while no hit is shown;
- the reported index stays in range.

The directed scenarios show the behaviour that depends on the programmed control words. These scenarios cover arming, mask widths including the reserved codes, direction filtering, context linking with in-range and out-of-range selectors, lowest-index priority, and how register writes take effect.

// File: rtl/wpbank_pkg.sv
package wpbank_pkg;

    localparam int CTRL_W = 13;

    // Control word layout, LSB first: arm, kind[1:0], mask[4:0], link_on, link_sel[3:0]
    typedef struct packed {
        logic [3:0] link_sel;
        logic       link_on;
        logic [4:0] mask_bits;
        logic [1:0] kind;
        logic       arm;
    } wp_ctrl_t;

    // Reserved mask codes 1 and 2 act as a full compare.
    function automatic logic [4:0] eff_mask(input logic [4:0] m);
        return (m == 5'd1 || m == 5'd2) ? 5'd0 : m;
    endfunction

    function automatic logic kind_allows(input logic [1:0] kind, input logic is_wr);
        return is_wr ? kind[1] : kind[0];
    endfunction

endpackage

// File: rtl/wp_regs.sv
module wp_regs
    import wpbank_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [3:0]        cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic [ADDR_W-1:0] val_q  [NUM_WP],
    output wp_ctrl_t          ctrl_q [NUM_WP]
);

    for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
        logic sel_me;
        assign sel_me = cfg_we && (cfg_idx == 4'(u));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[u]  <= '0;
                ctrl_q[u] <= '0;
            end else if (sel_me) begin
                if (cfg_sel) ctrl_q[u] <= wp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                else         val_q[u]  <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wp_cmp.sv
module wp_cmp
    import wpbank_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTX_W  = 4
) (
    input  logic [ADDR_W-1:0] val,
    input  wp_ctrl_t          ctrl,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_ifetch,
    input  logic [CTX_W-1:0]  ctx_match,
    output logic              match
);

    logic [ADDR_W-1:0] care;
    logic              addr_ok;
    logic              ctx_ok;

    always_comb begin
        care    = {ADDR_W{1'b1}} << eff_mask(ctrl.mask_bits);
        addr_ok = ((acc_addr ^ val) & care) == '0;
    end

    always_comb begin
        ctx_ok = 1'b0;
        for (int k = 0; k < CTX_W; k++) begin
            if (ctrl.link_sel == 4'(k)) ctx_ok = ctx_match[k];
        end
    end

    always_comb begin
        match = acc_valid && !acc_ifetch && ctrl.arm
             && kind_allows(ctrl.kind, acc_write)
             && addr_ok
             && (!ctrl.link_on || ctx_ok);
    end

endmodule

// File: rtl/wp_pick.sv
module wp_pick #(
    parameter int NUM_WP = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_WP-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_WP - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/wp_bank.sv
module wp_bank
    import wpbank_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    parameter int CTX_W  = 4,
    localparam int IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [3:0]        cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_ifetch,
    input  logic [CTX_W-1:0]  ctx_match,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [3:0]        id_units
);

    typedef enum logic {ST_WATCH, ST_REPORT} st_t;

    logic [ADDR_W-1:0] val_q  [NUM_WP];
    wp_ctrl_t          ctrl_q [NUM_WP];
    logic [NUM_WP-1:0] unit_match;
    logic              any_match;
    logic [IDX_W-1:0]  win_idx;
    st_t               state, state_nx;

    wp_regs #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .val_q(val_q), .ctrl_q(ctrl_q)
    );

    for (genvar u = 0; u < NUM_WP; u++) begin : g_cmp
        wp_cmp #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_cmp (
            .val(val_q[u]), .ctrl(ctrl_q[u]), .acc_valid(acc_valid),
            .acc_addr(acc_addr), .acc_write(acc_write), .acc_ifetch(acc_ifetch),
            .ctx_match(ctx_match), .match(unit_match[u])
        );
    end

    wp_pick #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_pick (
        .req(unit_match), .any(any_match), .idx(win_idx)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WATCH:  state_nx = any_match ? ST_REPORT : ST_WATCH;   // T_FIRE / T_IDLE
            ST_REPORT: state_nx = any_match ? ST_REPORT : ST_WATCH;   // T_REFIRE / T_CLEAR
            default:   state_nx = ST_WATCH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= state_nx;
    end

    // Output captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_idx    <= '0;
            fault_addr <= '0;
        end else if (any_match) begin
            hit_idx    <= win_idx;
            fault_addr <= acc_addr;
        end
    end

    assign hit      = (state == ST_REPORT);
    assign id_units = 4'(NUM_WP - 1);

endmodule

// File: rtl/wp_bank_chk.sv
module wp_bank_chk #(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ifetch,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              hit,
    input logic [IDX_W-1:0]  hit_idx,
    input logic [ADDR_W-1:0] fault_addr
);

    assert_fetch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ifetch) |=> !hit);

    assert_hit_needs_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid) |=> !hit);

    assert_fault_is_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (fault_addr == $past(acc_addr)));

    assert_fault_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> $stable(fault_addr));

    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(hit_idx) < NUM_WP));

endmodule

bind wp_bank wp_bank_chk #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ifetch(acc_ifetch),
    .acc_addr(acc_addr), .hit(hit), .hit_idx(hit_idx), .fault_addr(fault_addr)
);

// File: tb/tb_wp_bank.sv
module tb_wp_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int AW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [3:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          acc_valid = 1'b0, acc_write = 1'b0, acc_ifetch = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [CW-1:0] ctx_match = '0;
    logic          hit;
    logic [1:0]    hit_idx;
    logic [AW-1:0] fault_addr;
    logic [3:0]    id_units;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_bank #(.NUM_WP(NW), .ADDR_W(AW), .CTX_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_ifetch(acc_ifetch), .ctx_match(ctx_match),
        .hit(hit), .hit_idx(hit_idx), .fault_addr(fault_addr), .id_units(id_units)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input logic arm, input logic [1:0] kind,
                                        input logic [4:0] m, input logic lk, input logic [3:0] ls);
        return {19'd0, ls, lk, m, kind, arm};
    endfunction

    // one access, outputs checked the cycle after it is taken
    task automatic acc(input logic [31:0] a, input logic w, input logic f, input logic [3:0] cx);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_ifetch = f; ctx_match = cx;
        @(negedge clk);
        acc_valid = 1'b0; acc_ifetch = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 id", 32'(id_units), 32'(NW-1));
        check("R11 reset hit", 32'(hit), 0);
        check("R11 reset fault", fault_addr, 0);
        acc(32'h0, 1'b0, 1'b0, 4'h0);
        check("R11 reset units disarmed", 32'(hit), 0);
    endtask

    task automatic t_arm;
        wr(1'b0, 0, 32'h1000);
        wr(1'b1, 0, ctl(1'b0, 2'b11, 5'd0, 1'b0, 4'd0));
        acc(32'h1000, 1'b0, 1'b0, 4'h0);
        check("R2 disarmed", 32'(hit), 0);
        wr(1'b1, 0, ctl(1'b1, 2'b11, 5'd0, 1'b0, 4'd0));
        acc(32'h1000, 1'b0, 1'b0, 4'h0);
        check("R2 armed hit", 32'(hit), 1);
        check("R9 fault", fault_addr, 32'h1000);
        check("R8 idx", 32'(hit_idx), 0);
        acc(32'h2000, 1'b1, 1'b0, 4'h0);
        check("R10 cleared", 32'(hit), 0);
        check("R9 hold", fault_addr, 32'h1000);
    endtask

    task automatic t_mask;
        wr(1'b0, 1, 32'h4000);
        wr(1'b1, 1, ctl(1'b1, 2'b11, 5'd4, 1'b0, 4'd0));
        acc(32'h400C, 1'b1, 1'b0, 4'h0);
        check("R3 in range", 32'(hit), 1);
        check("R3 idx", 32'(hit_idx), 1);
        check("R3 fault", fault_addr, 32'h400C);
        acc(32'h4010, 1'b1, 1'b0, 4'h0);
        check("R3 out of range", 32'(hit), 0);
        wr(1'b1, 1, ctl(1'b1, 2'b11, 5'd2, 1'b0, 4'd0));
        acc(32'h4001, 1'b0, 1'b0, 4'h0);
        check("R4 mask2 exact", 32'(hit), 0);
        wr(1'b1, 1, ctl(1'b1, 2'b11, 5'd1, 1'b0, 4'd0));
        acc(32'h4001, 1'b0, 1'b0, 4'h0);
        check("R4 mask1 exact", 32'(hit), 0);
        acc(32'h4000, 1'b0, 1'b0, 4'h0);
        check("R4 exact hit", 32'(hit), 1);
    endtask

    task automatic t_kind;
        wr(1'b0, 2, 32'h5000);
        wr(1'b1, 2, ctl(1'b1, 2'b01, 5'd0, 1'b0, 4'd0));
        acc(32'h5000, 1'b1, 1'b0, 4'h0);
        check("R5 read-only ignores write", 32'(hit), 0);
        acc(32'h5000, 1'b0, 1'b0, 4'h0);
        check("R5 read-only read", 32'(hit), 1);
        wr(1'b1, 2, ctl(1'b1, 2'b10, 5'd0, 1'b0, 4'd0));
        acc(32'h5000, 1'b0, 1'b0, 4'h0);
        check("R5 write-only ignores read", 32'(hit), 0);
        acc(32'h5000, 1'b1, 1'b0, 4'h0);
        check("R5 write-only write", 32'(hit), 1);
        wr(1'b1, 2, ctl(1'b1, 2'b00, 5'd0, 1'b0, 4'd0));
        acc(32'h5000, 1'b1, 1'b0, 4'h0);
        check("R5 kind00 write", 32'(hit), 0);
        acc(32'h5000, 1'b0, 1'b0, 4'h0);
        check("R5 kind00 read", 32'(hit), 0);
    endtask

    task automatic t_fetch;
        wr(1'b1, 2, ctl(1'b1, 2'b11, 5'd0, 1'b0, 4'd0));
        acc(32'h5000, 1'b0, 1'b1, 4'h0);
        check("R6 fetch no hit", 32'(hit), 0);
        check("R6 fault unchanged", fault_addr, 32'h5000);
    endtask

    task automatic t_link;
        wr(1'b0, 3, 32'h6000);
        wr(1'b1, 3, ctl(1'b1, 2'b11, 5'd0, 1'b1, 4'd2));
        acc(32'h6000, 1'b0, 1'b0, 4'b0000);
        check("R7 ctx low", 32'(hit), 0);
        acc(32'h6000, 1'b0, 1'b0, 4'b1011);
        check("R7 other ctx", 32'(hit), 0);
        acc(32'h6000, 1'b0, 1'b0, 4'b0100);
        check("R7 ctx high", 32'(hit), 1);
        check("R7 idx", 32'(hit_idx), 3);
        wr(1'b1, 3, ctl(1'b1, 2'b11, 5'd0, 1'b1, 4'd9));
        acc(32'h6000, 1'b0, 1'b0, 4'b1111);
        check("R7 selector out of range", 32'(hit), 0);
    endtask

    task automatic t_prio;
        wr(1'b0, 0, 32'h7000);
        wr(1'b0, 3, 32'h7000);
        wr(1'b1, 3, ctl(1'b1, 2'b11, 5'd0, 1'b0, 4'd0));
        acc(32'h7000, 1'b1, 1'b0, 4'h0);
        check("R8 lowest wins", 32'(hit_idx), 0);
        wr(1'b1, 0, 32'h0);
        acc(32'h7000, 1'b1, 1'b0, 4'h0);
        check("R8 next unit", 32'(hit_idx), 3);
    endtask

    task automatic t_pulse;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h7000; acc_write = 1'b0; ctx_match = '0;
        @(negedge clk);
        check("R10 first", 32'(hit), 1);
        acc_addr = 32'h7000; acc_write = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 refire", 32'(hit), 1);
        @(negedge clk);
        check("R10 clear", 32'(hit), 0);
    endtask

    task automatic t_cfg;
        wr(1'b0, 3, 32'h8000);
        acc(32'h7000, 1'b0, 1'b0, 4'h0);
        check("R11 old address dropped", 32'(hit), 0);
        acc(32'h8000, 1'b0, 1'b0, 4'h0);
        check("R11 new address", 32'(hit), 1);
        wr(1'b1, 4, ctl(1'b0, 2'b00, 5'd0, 1'b0, 4'd0));
        wr(1'b1, 7, ctl(1'b0, 2'b00, 5'd0, 1'b0, 4'd0));
        acc(32'h8000, 1'b0, 1'b0, 4'h0);
        check("R11 out-of-range index ignored", 32'(hit), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_mask();
        t_kind();
        t_fetch();
        t_link();
        t_prio();
        t_pulse();
        t_cfg();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule